// File: doc/BRIEF.md
# Sum and Difference Frequency Synthesizer

This block takes two asynchronous square-wave inputs and produces two square-wave outputs. One output runs at the sum of the input frequencies and the other at their absolute difference. Each input is resynchronized and its rising edges are counted over a fixed gate window. The default window is a tenth of a second, which gives a resolution of 10 Hz per count. At the end of every window both counts are captured together and the counters restart.

The captured counts become phase-increment words for two phase-accumulator oscillators, so no analog or digital mixing is needed. A shared-shape sequential divider computes each word once per window as the measured frequency times 2^ACC_W over the clock frequency. This reduces to count × 2^ACC_W / GATE_CYCLES. Each oscillator's output is the top bit of its accumulator.

A small frequency jitter from the finite arithmetic is expected and accepted. The captured counts and a one-cycle strobe are brought out so they can be observed.

Top module: `sumdiff_synth`

## Requirements
- R1: While reset is held and in the first cycle after it, sum_out, diff_out, meas_valid, meas_a and meas_b are all 0.
- R2: meas_valid is high for exactly one cycle, once every GATE_CYCLES = CLK_HZ/GATE_HZ clock cycles. meas_a and meas_b both update in the cycle in which it is high.
- R3: meas_a (meas_b) equals the number of rising edges of in_a (in_b) seen during the last full window, after a two-flop synchronizer. The counters restart from zero in every window.
- R4: The sum tuning word is floor((meas_a+meas_b) × 2^ACC_W / GATE_CYCLES). sum_out is bit ACC_W-1 of an accumulator that adds this word every cycle, so sum_out has about meas_a+meas_b rising edges per window.
- R5: The difference tuning word is formed in the same way from |meas_a − meas_b|, whichever input is faster.
- R6: When the two counts are equal, the difference word is zero and diff_out keeps its level for the whole window.
- R7: A tuning word that would reach 2^(ACC_W−1) or more is held at 2^(ACC_W−1)−1. A saturated sum output therefore toggles on nearly every cycle.
- R8: Tuning words change only when a new computation finishes after a capture. The accumulators are never cleared by an update, so the outputs stay phase-continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First asynchronous square-wave input |
| in_b | input | 1 | Second asynchronous square-wave input |
| sum_out | output | 1 | Square wave at the sum frequency |
| diff_out | output | 1 | Square wave at the difference frequency |
| meas_valid | output | 1 | One-cycle strobe when new counts are captured |
| meas_a | output | CNT_W | Edge count of in_a from the last window |
| meas_b | output | CNT_W | Edge count of in_b from the last window |

## Verification
The inputs are driven at several pairs of periods:
- A faster first input, then a faster second input. Together these separate an absolute difference from a signed one.
- Equal periods, which must freeze the difference output.
- Two fast inputs whose sum stays just below the Nyquist limit.
- A sum above the Nyquist limit, where saturation gives about half a window of edges instead of an aliased lower count.
- Both inputs idle.

For every pair the bench checks the captured counts and the strobe spacing. It then counts output edges over a whole window after the new words have settled.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic {DIV_IDLE, DIV_RUN} div_state_t;
endpackage

// File: rtl/fx_edge_sync.sv
module fx_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [2:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[1:0], din};
  end

  // stage[1] is the synchronized level, stage[2] its previous value
  assign rise = stage[1] & ~stage[2];
endmodule

// File: rtl/fx_gate_meas.sv
module fx_gate_meas #(
  parameter int GATE_CYCLES = 2_400_000,
  parameter int CNT_W       = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_a,
  input  logic             rise_b,
  output logic             valid,
  output logic [CNT_W-1:0] cnt_out_a,
  output logic [CNT_W-1:0] cnt_out_b
);
  localparam int POS_W = $clog2(GATE_CYCLES);

  logic [POS_W-1:0] gate_pos;
  logic [CNT_W-1:0] run_a, run_b;
  logic             gate_end;

  assign gate_end = (gate_pos == POS_W'(GATE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_pos  <= '0;
      run_a     <= '0;
      run_b     <= '0;
      valid     <= 1'b0;
      cnt_out_a <= '0;
      cnt_out_b <= '0;
    end else begin
      valid <= gate_end;
      if (gate_end) begin
        gate_pos  <= '0;
        cnt_out_a <= run_a + CNT_W'(rise_a);
        cnt_out_b <= run_b + CNT_W'(rise_b);
        run_a     <= '0;
        run_b     <= '0;
      end else begin
        gate_pos <= gate_pos + 1'b1;
        run_a    <= run_a + CNT_W'(rise_a);
        run_b    <= run_b + CNT_W'(rise_b);
      end
    end
  end

  // R3: a running count can never exceed the cycles elapsed in the window
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    (32'(run_a) <= 32'(gate_pos)) && (32'(run_b) <= 32'(gate_pos)));

  // R2: the capture strobe lasts a single cycle
  a_r2_one_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/fx_tw_div.sv
module fx_tw_div #(
  parameter int IN_W  = 22,
  parameter int ACC_W = 24,
  parameter int DEN   = 2_400_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IN_W-1:0]  count,
  output logic [ACC_W-1:0] tw,
  output logic             done
);
  import fx_pkg::*;

  localparam int NUM_W  = IN_W + ACC_W;
  localparam int DEN_W  = $clog2(DEN + 1);
  localparam int STEP_W = $clog2(NUM_W) + 1;
  localparam logic [DEN_W:0] DEN_V = (DEN_W + 1)'(DEN);
  localparam logic [ACC_W-1:0] TW_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  // Saturate a full-width quotient to the largest word below Nyquist
  function automatic logic [ACC_W-1:0] sat_word(input logic [NUM_W-1:0] q);
    if (|q[NUM_W-1:ACC_W-1]) return TW_MAX;
    return q[ACC_W-1:0];
  endfunction

  div_state_t        state;
  logic [STEP_W-1:0] step;
  logic [NUM_W-1:0]  num, quo;
  logic [DEN_W-1:0]  rem;
  logic [DEN_W:0]    shifted, trial;
  logic              fits, last_step;

  assign shifted   = {rem, num[NUM_W-1]};
  assign fits      = (shifted >= DEN_V);
  assign trial     = fits ? (shifted - DEN_V) : shifted;
  assign last_step = (step == STEP_W'(NUM_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DIV_IDLE;
      step  <= '0;
      num   <= '0;
      quo   <= '0;
      rem   <= '0;
      tw    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state <= DIV_RUN;
        step  <= '0;
        num   <= {count, {ACC_W{1'b0}}};
        quo   <= '0;
        rem   <= '0;
      end else if (state == DIV_RUN) begin
        rem  <= trial[DEN_W-1:0];
        num  <= num << 1;
        quo  <= {quo[NUM_W-2:0], fits};
        step <= step + 1'b1;
        if (last_step) begin
          state <= DIV_IDLE;
          done  <= 1'b1;
          tw    <= sat_word({quo[NUM_W-2:0], fits});
        end
      end
    end
  end

  // R7: the word applied to the oscillator stays below Nyquist
  a_r7_below_nyquist: assert property (@(posedge clk) disable iff (rst)
    tw <= TW_MAX);

  // R8: the word moves only together with the completion pulse
  a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(tw));
endmodule

// File: rtl/fx_phase_acc.sv
module fx_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tw,
  output logic             wave
);
  logic [ACC_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + tw;
  end

  assign wave = phase[ACC_W-1];

  // R6: a zero word freezes the phase and therefore the output level
  a_r6_zero_word_hold: assert property (@(posedge clk) disable iff (rst)
    (tw == '0) |=> $stable(phase));
endmodule

// File: rtl/sumdiff_synth.sv
module sumdiff_synth #(
  parameter int CLK_HZ  = 24_000_000,
  parameter int GATE_HZ = 10,
  parameter int ACC_W   = 24,
  parameter int CNT_W   = $clog2(CLK_HZ / GATE_HZ / 2 + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_a,
  input  logic             in_b,
  output logic             sum_out,
  output logic             diff_out,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_a,
  output logic [CNT_W-1:0] meas_b
);
  localparam int GATE_CYCLES = CLK_HZ / GATE_HZ;
  localparam int SUM_W       = CNT_W + 1;

  function automatic logic [SUM_W-1:0] count_sum(input logic [CNT_W-1:0] x,
                                                 input logic [CNT_W-1:0] y);
    return SUM_W'(x) + SUM_W'(y);
  endfunction

  function automatic logic [SUM_W-1:0] count_gap(input logic [CNT_W-1:0] x,
                                                 input logic [CNT_W-1:0] y);
    return (x >= y) ? SUM_W'(x - y) : SUM_W'(y - x);
  endfunction

  logic             rise_a, rise_b;
  logic [SUM_W-1:0] total, gap;
  logic [ACC_W-1:0] tw_sum, tw_diff;
  logic             sum_done, diff_done;

  fx_edge_sync u_sync_a (.clk(clk), .rst(rst), .din(in_a), .rise(rise_a));
  fx_edge_sync u_sync_b (.clk(clk), .rst(rst), .din(in_b), .rise(rise_b));

  fx_gate_meas #(.GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .rise_a(rise_a), .rise_b(rise_b),
    .valid(meas_valid), .cnt_out_a(meas_a), .cnt_out_b(meas_b)
  );

  assign total = count_sum(meas_a, meas_b);
  assign gap   = count_gap(meas_a, meas_b);

  fx_tw_div #(.IN_W(SUM_W), .ACC_W(ACC_W), .DEN(GATE_CYCLES)) u_div_sum (
    .clk(clk), .rst(rst), .start(meas_valid), .count(total),
    .tw(tw_sum), .done(sum_done)
  );

  fx_tw_div #(.IN_W(SUM_W), .ACC_W(ACC_W), .DEN(GATE_CYCLES)) u_div_diff (
    .clk(clk), .rst(rst), .start(meas_valid), .count(gap),
    .tw(tw_diff), .done(diff_done)
  );

  fx_phase_acc #(.ACC_W(ACC_W)) u_osc_sum (
    .clk(clk), .rst(rst), .tw(tw_sum), .wave(sum_out)
  );

  fx_phase_acc #(.ACC_W(ACC_W)) u_osc_diff (
    .clk(clk), .rst(rst), .tw(tw_diff), .wave(diff_out)
  );

  // R8: both words are computed from the same capture and finish together
  a_r8_paired_update: assert property (@(posedge clk) disable iff (rst)
    sum_done == diff_done);

  // R5: equal captured counts yield a zero difference word once it settles
  a_r5_equal_gap: assert property (@(posedge clk) disable iff (rst)
    (diff_done && (gap == '0)) |-> (tw_diff == '0));
endmodule

// File: tb/test_sumdiff_synth.sv
module test_sumdiff_synth;
  localparam int CLK_HZ  = 10_000;
  localparam int GATE_HZ = 10;
  localparam int GATE    = CLK_HZ / GATE_HZ;
  localparam int CNT_W   = $clog2(GATE / 2 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0, in_b = 1'b0;
  logic sum_out, diff_out, meas_valid;
  logic [CNT_W-1:0] meas_a, meas_b;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  longint cyc = 0;
  int per_a = 0, per_b = 0;

  typedef struct { int pa; int pb; } case_t;
  case_t sb_q[$];

  sumdiff_synth #(.CLK_HZ(CLK_HZ), .GATE_HZ(GATE_HZ)) i_sumdiff_synth (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .sum_out(sum_out), .diff_out(diff_out), .meas_valid(meas_valid),
    .meas_a(meas_a), .meas_b(meas_b)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // input pattern generators: high for half the period, driven at falling edges
  initial begin
    int ka = 0;
    forever begin
      @(negedge clk);
      ka = (per_a == 0) ? 0 : (ka + 1) % per_a;
      in_a = (per_a != 0) && (ka < per_a / 2);
    end
  end
  initial begin
    int kb = 0;
    forever begin
      @(negedge clk);
      kb = (per_b == 0) ? 0 : (kb + 1) % per_b;
      in_b = (per_b != 0) && (kb < per_b / 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model: rising output edges per window for a given count
  function automatic longint edges_for(input longint cnt);
    longint w;
    w = (cnt << 24) / GATE;
    if (w >= (64'd1 << 23)) w = (64'd1 << 23) - 1;
    return (w * GATE) >> 24;
  endfunction

  task automatic wait_strobe();
    do @(negedge clk); while (!meas_valid);
  endtask

  task automatic run_case(input int pa, input int pb);
    case_t c;
    @(negedge clk);
    per_a = pa;
    per_b = pb;
    c.pa = pa;
    c.pb = pb;
    sb_q.push_back(c);
    wait (sb_q.size() == 0);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      case_t c;
      longint t1, ea, eb, es, ed;
      int ns, nd, tgl;
      logic ps, pd;
      wait (sb_q.size() > 0);
      c = sb_q[0];
      ea = (c.pa == 0) ? 0 : GATE / c.pa;
      eb = (c.pb == 0) ? 0 : GATE / c.pb;
      es = edges_for(ea + eb);
      ed = edges_for((ea > eb) ? ea - eb : eb - ea);
      wait_strobe();
      t1 = cyc;
      wait_strobe();
      chk(cyc - t1 == GATE, "R2 strobe spacing", cyc - t1, GATE);
      chk(meas_a == ea, "R3 count a", meas_a, ea);
      chk(meas_b == eb, "R3 count b", meas_b, eb);
      wait_strobe();
      ps = sum_out; pd = diff_out;
      ns = 0; nd = 0; tgl = 0;
      forever begin
        @(negedge clk);
        if (meas_valid) break;
        if (sum_out && !ps) ns++;
        if (diff_out && !pd) nd++;
        if (diff_out != pd) tgl++;
        ps = sum_out; pd = diff_out;
      end
      chk(ns == es || ns == es + 1, "R4 R7 R8 sum edges", ns, es);
      if (ea == eb)
        chk(tgl == 0, "R6 diff level held", tgl, 0);
      else
        chk(nd == ed || nd == ed + 1, "R5 diff edges", nd, ed);
      void'(sb_q.pop_front());
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(sum_out == 0 && diff_out == 0, "R1 outputs in reset", {sum_out, diff_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(meas_valid == 0, "R1 strobe after reset", meas_valid, 0);
    chk(meas_a == 0 && meas_b == 0, "R1 counts after reset", {meas_a, meas_b}, 0);
    chk(sum_out == 0 && diff_out == 0, "R1 outputs after reset", {sum_out, diff_out}, 0);
    run_case(20, 40);   // 50 and 25
    run_case(40, 20);   // swapped: absolute difference
    run_case(25, 25);   // equal counts
    run_case(4, 5);     // 250 and 200, just under Nyquist
    run_case(2, 4);     // 500 and 250, saturated sum
    run_case(0, 0);     // idle inputs
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule